// File: doc/BRIEF.md
# Packet Context Setup Sequencer

This block sits between a queue of packet-start descriptors and a group of parser engines. It pulls one descriptor at a time from the head of its input queue. Each descriptor carries a packet pointer, a length, a checksum and a timestamp. For each descriptor the block claims a free context slot in local memory. It records the descriptor in that slot's work-item word, copies the opening bytes of the packet into the slot's parse area, and writes zeros over the slot's metadata area. Only then does it post the slot number to one parser engine's queue.

Packet bytes come from a read port with a fixed latency that returns one byte per request. Local memory is written through two ports. One is a wide port for the work-item word. The other is a byte port for the parse and metadata areas. Parser engines are served strictly in turn. Slots stay claimed until the consumer returns them on the release input.

Top module: `pkt_ctx_seq`

## Requirements
- R1: The block pops the queue head (`in_pop` high for one cycle) only while it is idle, `in_empty` is low and at least one slot is free. It handles one descriptor per setup. The descriptor layout of `in_data` is pointer [79:64], length [63:48], checksum [47:32], timestamp [31:0].
- R2: The claimed slot is the lowest-numbered free slot. In the pop cycle, `wi_we` is high and `wi_slot`/`wi_data` carry that slot and the unmodified descriptor.
- R3: For byte positions k below both the length and PB_BYTES, the block requests address pointer+k (modulo 2^16) and writes the returned byte to parse index k. Requests go one per cycle, and each byte is written RD_LAT cycles after its request.
- R4: Parse positions at or beyond the packet length are written with zero, with no read request.
- R5: Every metadata byte (`lm_meta` = 1, index 0 to MD_BYTES-1) of the slot is written with zero.
- R6: The start message (`pr_push`, `pr_slot` = claimed slot) is issued only after all PB_BYTES+MD_BYTES byte writes for the slot are complete.
- R7: Parser engines receive start messages in round-robin order 0,1,...,NPARSER-1,0,..., starting at 0 after reset. `pr_push` is one-hot.
- R8: While the parser due next has `pr_full` high, the block holds the message and sends to no other parser. It sends to that parser once the queue has room.
- R9: With no free slot, `in_pop` stays low. A `rel_valid` pulse frees `rel_slot` from the next cycle on. A release in the same cycle as a pop is kept, and the pop still takes the slot picked from the pre-release free set.
- R10: After reset all slots are free and `in_pop`, `rd_req`, `wi_we`, `lm_we` and `pr_push` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_empty | input | 1 | Descriptor queue empty |
| in_data | input | 80 | Descriptor at the queue head |
| in_pop | output | 1 | Remove queue head |
| rel_valid | input | 1 | Return a slot |
| rel_slot | input | 2 | Slot being returned |
| rd_req | output | 1 | Packet-memory byte request |
| rd_addr | output | 16 | Packet-memory byte address |
| rd_data | input | 8 | Byte returned RD_LAT cycles after request |
| wi_we | output | 1 | Work-item word write |
| wi_slot | output | 2 | Slot of work-item write |
| wi_data | output | 80 | Work-item word |
| lm_we | output | 1 | Local byte write |
| lm_slot | output | 2 | Slot of byte write |
| lm_meta | output | 1 | 1 = metadata area, 0 = parse area |
| lm_idx | output | 3 | Byte index within area |
| lm_data | output | 8 | Byte value |
| pr_full | input | 3 | Per-parser queue full |
| pr_push | output | 3 | Per-parser queue write, one-hot |
| pr_slot | output | 2 | Slot number in start message |

## Verification
Slot return and slot claiming can fall in the same cycle. The bench provokes this by raising `rel_valid` for a low-numbered busy slot in the same cycle that a descriptor appears with a higher-numbered slot free. It expects the pop to take the higher slot, and the next descriptor to get the returned one. A second overlap is a full parser queue during a send. Here the message must wait with no push to any other engine until the full flag drops.

// File: rtl/pkt_ctx_seq.sv
module pkt_ctx_seq #(
  parameter int NSLOT    = 4,
  parameter int PB_BYTES = 8,
  parameter int MD_BYTES = 4,
  parameter int NPARSER  = 3,
  parameter int RD_LAT   = 2,
  parameter int PTR_W    = 16,
  parameter int LEN_W    = 16,
  parameter int CSUM_W   = 16,
  parameter int TS_W     = 32,
  localparam int WI_W    = PTR_W + LEN_W + CSUM_W + TS_W,
  localparam int SLOT_W  = NSLOT > 1 ? $clog2(NSLOT) : 1,
  localparam int PAR_W   = NPARSER > 1 ? $clog2(NPARSER) : 1,
  localparam int IDX_W   = $clog2(PB_BYTES > MD_BYTES ? PB_BYTES : MD_BYTES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_empty,
  input  logic [WI_W-1:0]    in_data,
  output logic               in_pop,
  input  logic               rel_valid,
  input  logic [SLOT_W-1:0]  rel_slot,
  output logic               rd_req,
  output logic [PTR_W-1:0]   rd_addr,
  input  logic [7:0]         rd_data,
  output logic               wi_we,
  output logic [SLOT_W-1:0]  wi_slot,
  output logic [WI_W-1:0]    wi_data,
  output logic               lm_we,
  output logic [SLOT_W-1:0]  lm_slot,
  output logic               lm_meta,
  output logic [IDX_W-1:0]   lm_idx,
  output logic [7:0]         lm_data,
  input  logic [NPARSER-1:0] pr_full,
  output logic [NPARSER-1:0] pr_push,
  output logic [SLOT_W-1:0]  pr_slot
);
  localparam int STEPS = PB_BYTES + MD_BYTES;
  localparam int CNT_W = $clog2(STEPS + RD_LAT + 1);

  typedef enum logic [1:0] {IDLE, STREAM, SEND} st_t;
  st_t st_q;

  logic [NSLOT-1:0]  busy_q;
  logic [SLOT_W-1:0] cur_q, pick;
  logic [PTR_W-1:0]  ptr_q;
  logic [LEN_W-1:0]  len_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [PAR_W-1:0]  rr_q;
  logic              have_free, issue, in_pb, sent;

  logic [RD_LAT-1:0] pv_q, prd_q, pm_q;
  logic [IDX_W-1:0]  pi_q [RD_LAT];

  always_comb begin
    have_free = 1'b0;
    pick = '0;
    for (int i = NSLOT - 1; i >= 0; i--)
      if (!busy_q[i]) begin
        have_free = 1'b1;
        pick = SLOT_W'(i);
      end
  end

  assign in_pop  = (st_q == IDLE) && !in_empty && have_free;
  assign wi_we   = in_pop;
  assign wi_slot = pick;
  assign wi_data = in_data;

  assign issue   = (st_q == STREAM) && (cnt_q < CNT_W'(STEPS));
  assign in_pb   = cnt_q < CNT_W'(PB_BYTES);
  assign rd_req  = issue && in_pb && (LEN_W'(cnt_q) < len_q);
  assign rd_addr = ptr_q + PTR_W'(cnt_q);

  assign lm_we   = pv_q[RD_LAT-1];
  assign lm_meta = pm_q[RD_LAT-1];
  assign lm_idx  = pi_q[RD_LAT-1];
  assign lm_data = prd_q[RD_LAT-1] ? rd_data : 8'h00;
  assign lm_slot = cur_q;

  always_comb begin
    pr_push = '0;
    if (st_q == SEND && !pr_full[rr_q]) pr_push[rr_q] = 1'b1;
  end
  assign sent    = |pr_push;
  assign pr_slot = cur_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv_q  <= '0;
      prd_q <= '0;
      pm_q  <= '0;
      for (int i = 0; i < RD_LAT; i++) pi_q[i] <= '0;
    end else begin
      pv_q[0]  <= issue;
      prd_q[0] <= rd_req;
      pm_q[0]  <= !in_pb;
      pi_q[0]  <= in_pb ? IDX_W'(cnt_q) : IDX_W'(cnt_q - CNT_W'(PB_BYTES));
      for (int i = 1; i < RD_LAT; i++) begin
        pv_q[i]  <= pv_q[i-1];
        prd_q[i] <= prd_q[i-1];
        pm_q[i]  <= pm_q[i-1];
        pi_q[i]  <= pi_q[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= IDLE;
      busy_q <= '0;
      cur_q  <= '0;
      ptr_q  <= '0;
      len_q  <= '0;
      cnt_q  <= '0;
      rr_q   <= '0;
    end else begin
      busy_q <= (busy_q & ~(rel_valid ? (NSLOT'(1) << rel_slot) : '0))
              | (in_pop ? (NSLOT'(1) << pick) : '0);
      case (st_q)
        IDLE: if (in_pop) begin
          st_q  <= STREAM;
          cur_q <= pick;
          ptr_q <= in_data[WI_W-1 -: PTR_W];
          len_q <= in_data[WI_W-PTR_W-1 -: LEN_W];
          cnt_q <= '0;
        end
        STREAM: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(STEPS + RD_LAT - 1)) st_q <= SEND;
        end
        default: if (sent) begin
          st_q <= IDLE;
          rr_q <= (rr_q == PAR_W'(NPARSER - 1)) ? '0 : rr_q + 1'b1;
        end
      endcase
    end
  end
endmodule

module pkt_ctx_seq_chk #(parameter int NPARSER = 3) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_empty,
  input logic               in_pop,
  input logic               lm_we,
  input logic               rd_req,
  input logic [NPARSER-1:0] pr_full,
  input logic [NPARSER-1:0] pr_push
);
  // R1
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n) in_pop |-> !in_empty);
  // R1
  single_pop_chk: assert property (@(posedge clk) disable iff (!rst_n) in_pop |=> !in_pop);
  // R6
  push_after_fill_chk: assert property (@(posedge clk) disable iff (!rst_n) (|pr_push) |-> (!lm_we && !rd_req));
  // R7
  push_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(pr_push));
  // R8
  no_full_push_chk: assert property (@(posedge clk) disable iff (!rst_n) (pr_push & pr_full) == '0);
endmodule

bind pkt_ctx_seq pkt_ctx_seq_chk #(.NPARSER(NPARSER)) chk_i (.*);

// File: tb/pkt_ctx_seq_tb.sv
`timescale 1ns/1ps
module pkt_ctx_seq_tb_top;
  localparam int NSLOT = 4, PB = 8, MD = 4, NP = 3;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        in_empty = 1'b1, in_pop;
  logic [79:0] in_data = '0;
  logic        rel_valid = 1'b0;
  logic [1:0]  rel_slot = '0;
  logic        rd_req;
  logic [15:0] rd_addr, a0, a1;
  logic [7:0]  rd_data;
  logic        wi_we, lm_we, lm_meta;
  logic [1:0]  wi_slot, lm_slot, pr_slot;
  logic [79:0] wi_data;
  logic [2:0]  lm_idx;
  logic [7:0]  lm_data;
  logic [2:0]  pr_full = '0, pr_push;

  always #4 clk = ~clk;

  pkt_ctx_seq dut_i (.*);

  function automatic logic [7:0] memb(input logic [15:0] a);
    return 8'(a * 13 + (a >> 8) + 5);
  endfunction

  always @(posedge clk) begin a0 <= rd_addr; a1 <= a0; end
  assign rd_data = memb(a1);

  localparam logic [15:0] T_PTR [5] = '{16'h0100, 16'h0203, 16'h0310, 16'h0400, 16'hFFFE};
  localparam logic [15:0] T_LEN [5] = '{16'd8, 16'd3, 16'd20, 16'd0, 16'd5};
  localparam logic [15:0] T_CS  [5] = '{16'h1111, 16'hBEEF, 16'h0042, 16'hFFFF, 16'h7A7A};
  localparam logic [31:0] T_TS  [5] = '{32'h1, 32'hDEAD0001, 32'h12345678, 32'h0, 32'hCAFEF00D};
  localparam logic        T_REL [5] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0};

  int nchk = 0, nfail = 0;
  int pops = 0, pushes = 0, wrc = 0, wrc_at_push = 0;
  int last_alloc = 0, last_pslot = 0, last_par = 0;
  logic [7:0]  pb [NSLOT][PB];
  logic [7:0]  mb [NSLOT][MD];
  logic [79:0] swi [NSLOT];
  logic        busy [NSLOT] = '{default: 1'b0};
  int          rr = 0;
  logic        pend_rel = 1'b0;
  int          pend_id = 0;

  always @(negedge clk) begin
    #2;
    if (wi_we) begin
      swi[wi_slot] = wi_data;
      for (int k = 0; k < PB; k++) pb[wi_slot][k] = 8'hA5;
      for (int k = 0; k < MD; k++) mb[wi_slot][k] = 8'hA5;
      wrc = 0; last_alloc = wi_slot; pops++;
    end
    if (lm_we) begin
      if (lm_meta) mb[lm_slot][lm_idx] = lm_data; else pb[lm_slot][lm_idx] = lm_data;
      wrc++;
    end
    if (|pr_push) begin
      pushes++; last_pslot = pr_slot; wrc_at_push = wrc;
      for (int i = 0; i < NP; i++) if (pr_push[i]) last_par = i;
    end
  end

  task automatic chk(input logic ok, input string req, input logic [79:0] act, input logic [79:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic present(input logic [15:0] p, input logic [15:0] l, input logic [15:0] c,
                         input logic [31:0] t, input logic dr, input int rid);
    @(negedge clk);
    in_data = {p, l, c, t};
    in_empty = 1'b0;
    pend_rel = dr; pend_id = rid;
    if (dr) begin rel_valid = 1'b1; rel_slot = 2'(rid); end
  endtask

  task automatic finish(input int p0, input logic hold_full);
    int q0, exp_slot, n;
    logic [79:0] d;
    logic [7:0]  e;
    q0 = pushes; d = in_data;
    n = 0;
    #3;
    while (pops == p0 && n < 200) begin @(negedge clk); #3; n++; end
    chk(pops == p0 + 1, "R1 pop count", 80'(pops - p0), 80'd1);
    exp_slot = -1;
    for (int i = NSLOT - 1; i >= 0; i--) if (!busy[i]) exp_slot = i;
    chk(last_alloc == exp_slot, "R2 slot", 80'(last_alloc), 80'(exp_slot));
    if (exp_slot >= 0) busy[exp_slot] = 1'b1;
    if (pend_rel) busy[pend_id] = 1'b0;
    pend_rel = 1'b0;
    @(negedge clk);
    in_empty = 1'b1; rel_valid = 1'b0;
    if (hold_full) begin
      repeat (40) @(negedge clk);
      #3;
      chk(pushes == q0, "R8 held while full", 80'(pushes - q0), 80'd0);
      @(negedge clk);
      pr_full = '0;
    end
    n = 0;
    #3;
    while (pushes == q0 && n < 200) begin @(negedge clk); #3; n++; end
    chk(pushes == q0 + 1, "R6 push seen", 80'(pushes - q0), 80'd1);
    chk(last_pslot == last_alloc, "R6 pr_slot", 80'(last_pslot), 80'(last_alloc));
    chk(wrc_at_push == PB + MD, "R6 writes before push", 80'(wrc_at_push), 80'(PB + MD));
    chk(last_par == rr, "R7 parser order", 80'(last_par), 80'(rr));
    rr = (rr + 1) % NP;
    chk(swi[last_alloc] == d, "R2 work item", swi[last_alloc], d);
    for (int k = 0; k < PB; k++) begin
      e = (k < int'(d[63:48])) ? memb(d[79:64] + 16'(k)) : 8'h00;
      chk(pb[last_alloc][k] == e, (k < int'(d[63:48])) ? "R3 parse byte" : "R4 zero fill",
          80'(pb[last_alloc][k]), 80'(e));
    end
    for (int k = 0; k < MD; k++)
      chk(mb[last_alloc][k] == 8'h00, "R5 meta clear", 80'(mb[last_alloc][k]), 80'd0);
  endtask

  task automatic run_pkt(input logic [15:0] p, input logic [15:0] l, input logic [15:0] c,
                         input logic [31:0] t, input logic dr, input int rid);
    int p0;
    p0 = pops;
    present(p, l, c, t, dr, rid);
    finish(p0, 1'b0);
  endtask

  task automatic rel_pulse(input int id);
    @(negedge clk);
    rel_valid = 1'b1; rel_slot = 2'(id);
    @(negedge clk);
    rel_valid = 1'b0;
    busy[id] = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int p0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
    // R10 reset state
    chk(!in_pop && !wi_we, "R10 pop idle", 80'(in_pop), 80'd0);
    chk(!rd_req && !lm_we, "R10 no access", 80'({rd_req, lm_we}), 80'd0);
    chk(pr_push == '0, "R10 no push", 80'(pr_push), 80'd0);

    for (int i = 0; i < 5; i++) begin
      run_pkt(T_PTR[i], T_LEN[i], T_CS[i], T_TS[i], 1'b0, 0);
      if (T_REL[i]) rel_pulse(last_alloc);
    end

    run_pkt(16'h1234, 16'd8, 16'h5555, 32'h11223344, 1'b0, 0);
    // R9 stall with all slots busy
    p0 = pops;
    present(16'h2000, 16'd6, 16'h0001, 32'h0BADBEEF, 1'b0, 0);
    repeat (30) @(negedge clk);
    #3;
    chk(pops == p0, "R9 stall no slot", 80'(pops - p0), 80'd0);
    rel_pulse(1);
    finish(p0, 1'b0);

    // R8 next parser full
    rel_pulse(3);
    pr_full = 3'(1 << rr);
    p0 = pops;
    present(16'h3000, 16'd7, 16'h0002, 32'h00000077, 1'b0, 0);
    finish(p0, 1'b1);

    // R9 release in the same cycle as allocation
    rel_pulse(2);
    run_pkt(16'h4000, 16'd2, 16'h0003, 32'h00000099, 1'b1, 0);
    run_pkt(16'h5000, 16'd9, 16'h0004, 32'h000000AA, 1'b0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule